// File: doc/BRIEF.md
# Terminal receiver register interface

This block is the keyboard side of a serial console port on a 16-bit I/O bus. Software sees two registers. A control/status word carries a "character waiting" flag and an interrupt-enable bit. An 8-bit receive holding register is read-only. An external deserializer, which is not part of this block, presents each finished character with a one-cycle valid strobe and a break indication. The block captures the character and raises a level interrupt request when enabled.

Software normally works in one of two ways. It can poll the waiting flag through the status word. It can also set the enable bit and wait for the request line. Either way it then reads the holding register. That read has a side effect: it consumes the character, clearing the waiting flag and dropping the request in the same access. Bus accesses are single-cycle strobes. Read data is valid combinationally while the read strobe is high, and the side effects take place at the closing clock edge.

Top module: `term_rx_regs`

## Requirements
- R1: After a synchronous active-low reset, the holding register is 0, the status word reads 0 and irq is low.
- R2: Address bit 1 (bus_addr[1]) selects the register: 0 is the status word and 1 is the holding register. A status read returns the waiting flag in bit 7, the enable in bit 6, and zeros in every other bit.
- R3: A holding-register read returns the character in bits 7..0 with bits 15..8 zero. At the closing edge it clears the waiting flag and drops irq.
- R4: A status write stores only bit 6 as the enable. Every other written bit is ignored, including bit 7, so a write can never set or clear the waiting flag.
- R5: A byte write (bus_byte=1) to the high byte of the status word (bus_addr[0]=1) changes nothing.
- R6: Writes to the holding-register address change nothing.
- R7: When rx_valid is high, the holding register loads the character and the waiting flag is set. irq rises at the same edge if the enable after that edge is 1. At every cycle out of reset, irq equals waiting AND enable.
- R8: When rx_valid arrives with rx_break high, the holding register loads 0 instead of rx_char.
- R9: A status write with bit 6 = 0 drops irq at that edge. A status write with bit 6 = 1, made while a character is waiting and the enable was 0, raises irq at that edge.
- R10: A character that arrives while the waiting flag is still set overwrites the holding register. The newest character is kept and no error is flagged.
- R11: If a character arrives in the same cycle as a holding-register read, the read returns the old character. The new character is kept, and the waiting flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte address bits [1:0] within the register pair |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while a read strobe is high, else 0 |
| rx_valid | input | 1 | One-cycle strobe from the deserializer: character complete |
| rx_break | input | 1 | Qualifies rx_valid as a break condition |
| rx_char | input | 8 | Received character |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a character that arrives in exactly the cycle software reads the holding register. In that cycle two updates compete for the waiting flag, and a one-cycle slip in either hides the fault. The bench creates this collision on purpose with directed steps. It also aligns rx_valid with status writes that flip the enable. Random traffic then mixes all operations with a high arrival rate, so these collisions and overwrite cases also recur without being directed.

// File: rtl/term_rx_pkg.sv
// Shared constants for the terminal receiver register pair.
// Assumes a 16-bit data bus and an 8-bit character path.
package term_rx_pkg;
    parameter int DATA_W   = 16;
    parameter int CHAR_W   = 8;
    parameter int DONE_BIT = 7;   // waiting flag position in the status word
    parameter int IE_BIT   = 6;   // interrupt enable position in the status word
    parameter int ADDR_W   = 2;
endpackage

// File: rtl/term_rx_decode.sv
// Turns a bus strobe into per-register actions.
// Assumes one access per strobe cycle; bus_addr[1] selects register,
// bus_addr[0] with bus_byte marks a high-byte access.
module term_rx_decode
    import term_rx_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_byte,
    output logic              csr_rd,
    output logic              csr_wr,
    output logic              buf_rd
);
    logic hi_byte;
    logic sel_buf;

    // Decode register select and the ignored high-byte write.
    always_comb begin
        hi_byte = bus_byte & bus_addr[0];
        sel_buf = bus_addr[1];
        csr_rd  = bus_sel & ~bus_wr & ~sel_buf;
        buf_rd  = bus_sel & ~bus_wr &  sel_buf;
        csr_wr  = bus_sel &  bus_wr & ~sel_buf & ~hi_byte;
    end
endmodule

// File: rtl/term_rx_csr.sv
// Holds the waiting flag and the interrupt enable.
// Assumes rx_valid wins over a simultaneous holding-register read.
module term_rx_csr
    import term_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              buf_rd,
    input  logic              rx_valid,
    output logic              done,
    output logic              ie,
    output logic              ie_wr_val
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;
    assign ie_wr_val    = wdata[IE_BIT];

    // Enable register: only written by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie <= 1'b0;
        else if (csr_wr) ie <= ie_wr_val;
    end

    // Waiting flag: set by arrival, cleared by a buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (rx_valid) done <= 1'b1;
        else if (buf_rd)   done <= 1'b0;
    end

    // R4
    done_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !rx_valid) |=> (done == $past(done)));
    // R11
    arrive_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> done);
endmodule

// File: rtl/term_rx_buf.sv
// Receive holding register.
// Assumes break loads zero and every arrival overwrites unconditionally.
module term_rx_buf
    import term_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [CHAR_W-1:0] rx_char,
    output logic [CHAR_W-1:0] held
);
    // Capture the character, or zero on break.
    always_ff @(posedge clk) begin
        if (!rst_n)        held <= '0;
        else if (rx_valid) held <= rx_break ? '0 : rx_char;
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(held));
    // R8
    break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |=> (held == '0));
endmodule

// File: rtl/term_rx_irq.sv
// Level interrupt request, updated by event rules.
// Assumes a status write and a buffer read never share a cycle.
module term_rx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic csr_wr,
    input  logic ie_wr_val,
    input  logic buf_rd,
    input  logic rx_valid,
    input  logic done,
    input  logic ie,
    output logic irq
);
    logic ie_next;
    logic irq_next;

    // Next-state rules for the request.
    always_comb begin
        ie_next  = csr_wr ? ie_wr_val : ie;
        irq_next = irq;
        if (buf_rd) irq_next = 1'b0;
        if (csr_wr) begin
            if (!ie_wr_val)      irq_next = 1'b0;
            else if (done && !ie) irq_next = 1'b1;
        end
        if (rx_valid && ie_next) irq_next = 1'b1;
    end

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_next;
    end

    // R9
    ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !ie_wr_val) |=> !irq);
    // R3
    read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !rx_valid) |=> !irq);
endmodule

// File: rtl/term_rx_regs.sv
// Top of the terminal receiver register pair: decode, status,
// holding register, interrupt request and read mux.
// Assumes single-cycle bus strobes with combinational read data.
module term_rx_regs
    import term_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_byte,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              irq
);
    logic              csr_rd, csr_wr, buf_rd;
    logic              done, ie, ie_wr_val;
    logic [CHAR_W-1:0] held;

    term_rx_decode u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_byte(bus_byte), .csr_rd(csr_rd), .csr_wr(csr_wr), .buf_rd(buf_rd)
    );

    term_rx_csr u_csr (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .wdata(bus_wdata),
        .buf_rd(buf_rd), .rx_valid(rx_valid), .done(done), .ie(ie),
        .ie_wr_val(ie_wr_val)
    );

    term_rx_buf u_buf (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
        .rx_char(rx_char), .held(held)
    );

    term_rx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .ie_wr_val(ie_wr_val),
        .buf_rd(buf_rd), .rx_valid(rx_valid), .done(done), .ie(ie), .irq(irq)
    );

    // Read mux: status bits, zero-extended character, or zero.
    always_comb begin
        bus_rdata = '0;
        if (csr_rd) begin
            bus_rdata[DONE_BIT] = done;
            bus_rdata[IE_BIT]   = ie;
        end else if (buf_rd) begin
            bus_rdata[CHAR_W-1:0] = held;
        end
    end

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (done && ie));
    // R1
    reset_irq_chk: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/sim_term_rx_regs.sv
module sim_term_rx_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr, bus_byte;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        rx_valid, rx_break;
    logic [7:0]  rx_char;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [7:0] m_buf;
    logic       m_done, m_ie, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_rx_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_break(rx_break),
        .rx_char(rx_char), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] v = '0;
        v[7] = m_done;
        v[6] = m_ie;
        return v;
    endfunction

    // One bus/receive cycle; model updated after the edge.
    task automatic step(input logic sel, input logic wr, input logic [1:0] addr,
                        input logic bt, input logic [15:0] wd,
                        input logic rv, input logic rb, input logic [7:0] rc,
                        input string tag);
        logic [7:0] nb;
        logic nd, ni, nq;
        @(negedge clk);
        check({tag, " irq R7"}, {15'b0, irq}, {15'b0, m_irq});
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_byte = bt; bus_wdata = wd;
        rx_valid = rv; rx_break = rb; rx_char = rc;
        #1;
        if (sel && !wr) begin
            if (addr[1]) check({tag, " bufread R3"}, bus_rdata, {8'h00, m_buf});
            else         check({tag, " status R2"}, bus_rdata, exp_status());
        end
        nb = m_buf; nd = m_done; ni = m_ie; nq = m_irq;
        if (sel && !wr && addr[1]) begin nd = 1'b0; nq = 1'b0; end
        if (sel && wr && !addr[1] && !(bt && addr[0])) begin
            ni = wd[6];
            if (!wd[6]) nq = 1'b0;
            else if (m_done && !m_ie) nq = 1'b1;
        end
        if (rv) begin
            nb = rb ? 8'h00 : rc;
            nd = 1'b1;
            if (ni) nq = 1'b1;
        end
        @(posedge clk);
        m_buf = nb; m_done = nd; m_ie = ni; m_irq = nq;
        #1;
        bus_sel = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic rd_stat(input string t); step(1,0,2'b00,0,16'h0,0,0,8'h0,t); endtask
    task automatic rd_buf(input string t);  step(1,0,2'b10,0,16'h0,0,0,8'h0,t); endtask
    task automatic idle(input string t);    step(0,0,2'b00,0,16'h0,0,0,8'h0,t); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_byte = 0;
        bus_wdata = 0; rx_valid = 0; rx_break = 0; rx_char = 0;
        m_buf = 0; m_done = 0; m_ie = 0; m_irq = 0;
        // R1: dirty the block, then reset
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        step(0,0,0,0,0,1,0,8'hA5,"pre");
        step(1,1,2'b00,0,16'h0040,0,0,0,"pre");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        m_buf = 0; m_done = 0; m_ie = 0; m_irq = 0;
        @(negedge clk);
        check("reset irq R1", {15'b0, irq}, 16'h0);
        rst_n = 1'b1;
        rd_stat("reset R1");
        rd_buf("reset R1");
        // R7 polled arrival, R3 consume
        step(0,0,0,0,0,1,0,8'h41,"arrive R7");
        rd_stat("done R2");
        rd_buf("consume R3");
        rd_stat("after read R3");
        // R4 only bit6 writable; bit7 ignored
        step(1,1,2'b00,0,16'hFFBF,0,0,0,"wr R4");
        rd_stat("wr R4");
        // R9 enable while waiting raises irq
        step(0,0,0,0,0,1,0,8'h5A,"arrive R9");
        step(1,1,2'b00,0,16'h0040,0,0,0,"enable R9");
        idle("irq up R9");
        step(1,1,2'b00,0,16'h0000,0,0,0,"disable R9");
        idle("irq down R9");
        // R5 high-byte write ignored
        step(1,1,2'b01,1,16'hFFFF,0,0,0,"hibyte R5");
        rd_stat("hibyte R5");
        // R6 buffer writes ignored
        step(1,1,2'b10,0,16'h00EE,0,0,0,"bufwr R6");
        rd_buf("bufwr R6");
        // R8 break
        step(1,1,2'b00,0,16'h0040,0,0,0,"en R8");
        step(0,0,0,0,0,1,1,8'h77,"break R8");
        rd_buf("break R8");
        // R10 overwrite
        step(0,0,0,0,0,1,0,8'h11,"ovr R10");
        step(0,0,0,0,0,1,0,8'h22,"ovr R10");
        rd_buf("ovr R10");
        // R11 arrival during read
        step(0,0,0,0,0,1,0,8'h33,"col R11");
        step(1,0,2'b10,0,0,1,0,8'h44,"col R11");
        rd_stat("col R11");
        rd_buf("col R11");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 5);
            logic rv = ($urandom_range(0, 2) == 0);
            logic rb = ($urandom_range(0, 7) == 0);
            logic [7:0] rc = 8'($urandom);
            logic [15:0] wd = 16'($urandom);
            case (op)
                0: step(1,0,{1'b0,1'($urandom)},1'($urandom),0,rv,rb,rc,"rnd R2");
                1: step(1,0,{1'b1,1'($urandom)},1'($urandom),0,rv,rb,rc,"rnd R11");
                2: step(1,1,{1'b0,1'($urandom)},1'($urandom),wd,rv,rb,rc,"rnd R9");
                3: step(1,1,{1'b1,1'($urandom)},1'($urandom),wd,rv,rb,rc,"rnd R6");
                default: step(0,0,0,0,0,rv,rb,rc,"rnd R10");
            endcase
        end
        rd_stat("final R2");
        rd_buf("final R3");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule